// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the next instruction address for a small processor. It holds an 11-bit program counter and a five-entry return-address stack. It also holds a three-bit upper-address buffer that only software writes. Each instruction cycle it takes decoded control strobes from the instruction decoder: sequential fetch, jump, call, return and a write to the low address byte. With them it takes the instruction's address field and the data bus, and it forms the next program counter value.

The upper program-counter bits are never loaded straight from the data bus. Jumps and calls take their top bit from the buffer. A write to the low byte takes all three upper bits from it. The buffer is never loaded back from the program counter. The low address byte is available as a readable value, and the buffer contents are visible on an output.

Top module: `pc_seq`

## Requirements
- R1: When `step` is low, the program counter, the upper buffer and the stack do not change, whatever the other control inputs are.
- R2: On a step with no control strobe, the program counter increments by one, modulo 2^11 (0x7FF is followed by 0x000).
- R3: On a jump, the new program counter is formed as follows: bits 9:0 come from `addr_field`, and bit 10 comes from buffer bit 2.
- R4: A call forms its target in the same way as a jump. It also pushes the old program counter plus one (modulo 2^11) onto the stack.
- R5: A return loads the program counter from the most recently pushed entry and removes that entry from the stack.
- R6: A low-byte write sets program counter bits 7:0 to `data_in[7:0]` and bits 10:8 to buffer bits 2:0.
- R7: The buffer changes only on a step with `hb_wr` high, and then takes `data_in[2:0]`. Jumps, calls, returns and low-byte writes never change it. A target formed in the same cycle as a buffer write uses the buffer's previous value.
- R8: The stack is a ring of five entries. A sixth push overwrites the oldest entry. The pointer wraps in both directions, so after six pushes, six pops return the last five pushed values newest first and then the sixth-pushed value again.
- R9: Reset, synchronous and active high, clears the program counter, the buffer and the stack pointer to zero.
- R10: When several strobes are high in one step, the order of precedence is return, then call, then jump, then low-byte write. Only the winning action takes effect on the program counter and the stack.
- R11: `pcl_rd` always equals bits 7:0 of `pc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction cycle enable |
| do_jump | input | 1 | Jump strobe |
| do_call | input | 1 | Call strobe |
| do_ret | input | 1 | Return strobe (any return variant) |
| do_pcl_wr | input | 1 | Instruction writes the low address byte |
| hb_wr | input | 1 | Software write to the upper buffer |
| addr_field | input | 10 | Address field of the instruction word |
| data_in | input | 8 | Data bus value |
| pc_out | output | 11 | Current program counter |
| pcl_rd | output | 8 | Readable low address byte |
| hb_out | output | 3 | Upper buffer contents |

## Verification
The hardest situation to reach from the ports is the wrap of the stack ring. It needs more nested calls than the stack is deep, followed by more returns than remain valid, with every return address still predictable. The bench gets there with a directed run of six calls, each to a different target, followed by six returns. It then mixes random strobes with simultaneous strobe combinations, which checks the order of precedence against a behavioural model on every cycle.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_SEQ  = 3'd1,
    SRC_JUMP = 3'd2,
    SRC_CALL = 3'd3,
    SRC_RET  = 3'd4,
    SRC_LOW  = 3'd5
  } pc_src_t;
endpackage

// File: rtl/pc_src_sel.sv
module pc_src_sel
  import pc_seq_pkg::*;
(
  input  logic    step,
  input  logic    do_jump,
  input  logic    do_call,
  input  logic    do_ret,
  input  logic    do_pcl_wr,
  output pc_src_t src
);
  // R10: return > call > jump > low-byte write > sequential
  always_comb begin
    if (!step)          src = SRC_HOLD;
    else if (do_ret)    src = SRC_RET;
    else if (do_call)   src = SRC_CALL;
    else if (do_jump)   src = SRC_JUMP;
    else if (do_pcl_wr) src = SRC_LOW;
    else                src = SRC_SEQ;
  end
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int JA_W  = 10,
  parameter int LOW_W = 8,
  localparam int HB_W = PC_W - LOW_W,
  localparam int TOPW = PC_W - JA_W
) (
  input  pc_src_t           src,
  input  logic [PC_W-1:0]   pc,
  input  logic [JA_W-1:0]   addr_field,
  input  logic [LOW_W-1:0]  data_low,
  input  logic [HB_W-1:0]   hb,
  input  logic [PC_W-1:0]   stack_top,
  output logic [PC_W-1:0]   pc_inc,
  output logic [PC_W-1:0]   pc_next
);
  logic [PC_W-1:0] far_target;

  assign pc_inc     = pc + PC_W'(1);
  assign far_target = {hb[HB_W-1 -: TOPW], addr_field};

  always_comb begin
    unique case (src)
      SRC_SEQ:  pc_next = pc_inc;
      SRC_JUMP: pc_next = far_target;
      SRC_CALL: pc_next = far_target;
      SRC_RET:  pc_next = stack_top;
      SRC_LOW:  pc_next = {hb, data_low};
      default:  pc_next = pc;
    endcase
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 11,
  parameter int DEPTH = 5,
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  logic [W-1:0]    ring [DEPTH];
  logic [SP_W-1:0] sp, sp_up, sp_dn;

  assign sp_up    = (sp == SP_W'(DEPTH-1)) ? '0 : sp + SP_W'(1);
  assign sp_dn    = (sp == '0) ? SP_W'(DEPTH-1) : sp - SP_W'(1);
  assign top_data = ring[sp_dn];

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) ring[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp_up;
    else if (pop)  sp <= sp_dn;
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int JA_W  = 10,
  parameter int LOW_W = 8,
  parameter int DEPTH = 5,
  localparam int HB_W = PC_W - LOW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             do_jump,
  input  logic             do_call,
  input  logic             do_ret,
  input  logic             do_pcl_wr,
  input  logic             hb_wr,
  input  logic [JA_W-1:0]  addr_field,
  input  logic [LOW_W-1:0] data_in,
  output logic [PC_W-1:0]  pc_out,
  output logic [LOW_W-1:0] pcl_rd,
  output logic [HB_W-1:0]  hb_out
);
  pc_src_t          src;
  logic [PC_W-1:0]  pc_q, pc_inc, pc_next, top;
  logic [LOW_W-1:0] pcl_q;
  logic [HB_W-1:0]  hb_q;

  pc_src_sel u_sel (
    .step(step), .do_jump(do_jump), .do_call(do_call),
    .do_ret(do_ret), .do_pcl_wr(do_pcl_wr), .src(src)
  );

  pc_next_mux #(.PC_W(PC_W), .JA_W(JA_W), .LOW_W(LOW_W)) u_mux (
    .src(src), .pc(pc_q), .addr_field(addr_field), .data_low(data_in),
    .hb(hb_q), .stack_top(top), .pc_inc(pc_inc), .pc_next(pc_next)
  );

  pc_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst),
    .push(src == SRC_CALL), .pop(src == SRC_RET),
    .push_data(pc_inc), .top_data(top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      pcl_q <= '0;
      hb_q  <= '0;
    end else begin
      pc_q  <= pc_next;
      pcl_q <= pc_next[LOW_W-1:0];
      if (step && hb_wr) hb_q <= data_in[HB_W-1:0];
    end
  end

  assign pc_out = pc_q;
  assign pcl_rd = pcl_q;
  assign hb_out = hb_q;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W  = 11,
  parameter int JA_W  = 10,
  parameter int LOW_W = 8,
  localparam int HB_W = PC_W - LOW_W,
  localparam int TOPW = PC_W - JA_W
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             do_jump,
  input logic             do_call,
  input logic             do_ret,
  input logic             do_pcl_wr,
  input logic             hb_wr,
  input logic [JA_W-1:0]  addr_field,
  input logic [LOW_W-1:0] data_in,
  input logic [PC_W-1:0]  pc_out,
  input logic [LOW_W-1:0] pcl_rd,
  input logic [HB_W-1:0]  hb_out
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pc_out) && $stable(hb_out));

  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    step && !do_jump && !do_call && !do_ret && !do_pcl_wr
    |=> pc_out == PC_W'($past(pc_out) + PC_W'(1)));

  assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
    step && do_jump && !do_call && !do_ret
    |=> pc_out == {$past(hb_out[HB_W-1 -: TOPW]), $past(addr_field)});

  assert_call_R4: assert property (@(posedge clk) disable iff (rst)
    step && do_call && !do_ret
    |=> pc_out == {$past(hb_out[HB_W-1 -: TOPW]), $past(addr_field)});

  assert_low_R6: assert property (@(posedge clk) disable iff (rst)
    step && do_pcl_wr && !do_jump && !do_call && !do_ret
    |=> pc_out == {$past(hb_out), $past(data_in)});

  assert_hbkeep_R7: assert property (@(posedge clk) disable iff (rst)
    !(step && hb_wr) |=> $stable(hb_out));

  assert_hbload_R7: assert property (@(posedge clk) disable iff (rst)
    step && hb_wr |=> hb_out == $past(data_in[HB_W-1:0]));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> pc_out == '0 && hb_out == '0);

  assert_pclread_R11: assert property (@(posedge clk) disable iff (rst)
    pcl_rd == pc_out[LOW_W-1:0]);
endmodule

bind pc_seq pc_seq_chk #(.PC_W(PC_W), .JA_W(JA_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .do_jump(do_jump), .do_call(do_call),
  .do_ret(do_ret), .do_pcl_wr(do_pcl_wr), .hb_wr(hb_wr),
  .addr_field(addr_field), .data_in(data_in), .pc_out(pc_out),
  .pcl_rd(pcl_rd), .hb_out(hb_out)
);

// File: tb/sim_pc_seq.sv
`timescale 1ns/1ps
module sim_pc_seq;
  logic clk = 0, rst = 1, step = 0;
  logic do_jump = 0, do_call = 0, do_ret = 0, do_pcl_wr = 0, hb_wr = 0;
  logic [9:0]  addr_field = '0;
  logic [7:0]  data_in = '0;
  logic [10:0] pc_out;
  logic [7:0]  pcl_rd;
  logic [2:0]  hb_out;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pc, m_hb, m_sp;
  int m_ring [5];

  always #4 clk = ~clk;  // 125 MHz

  pc_seq u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural model of one cycle
  task automatic model_update();
    int nxt;
    if (rst) begin m_pc = 0; m_hb = 0; m_sp = 0; return; end
    if (!step) return;
    nxt = m_pc;
    if (do_ret) begin
      m_sp = (m_sp + 4) % 5;
      nxt = m_ring[m_sp];
    end else if (do_call) begin
      m_ring[m_sp] = (m_pc + 1) % 2048;
      m_sp = (m_sp + 1) % 5;
      nxt = ((m_hb >> 2) & 1) * 1024 + addr_field;
    end else if (do_jump) begin
      nxt = ((m_hb >> 2) & 1) * 1024 + addr_field;
    end else if (do_pcl_wr) begin
      nxt = m_hb * 256 + data_in;
    end else begin
      nxt = (m_pc + 1) % 2048;
    end
    if (hb_wr) m_hb = data_in & 7;
    m_pc = nxt;
  endtask

  function automatic string pick_tag();
    if (rst) return "R9";
    if (!step) return "R1";
    if (do_ret + do_call + do_jump + do_pcl_wr > 1) return "R10";
    if (do_ret) return "R5";
    if (do_call) return "R4";
    if (do_jump) return "R3";
    if (do_pcl_wr) return "R6";
    return "R2";
  endfunction

  // inputs already set at a negedge; advance and compare
  task automatic cyc(string tag = "");
    string t;
    t = (tag == "") ? pick_tag() : tag;
    model_update();
    @(posedge clk);
    @(negedge clk);
    chk(t, pc_out, m_pc);
    chk("R7", hb_out, m_hb);
    chk("R11", pcl_rd, pc_out[7:0]);
  endtask

  task automatic set(bit s, bit j, bit c, bit r, bit l, bit h, int a, int d);
    step = s; do_jump = j; do_call = c; do_ret = r; do_pcl_wr = l; hb_wr = h;
    addr_field = 10'(a); data_in = 8'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    set(1, 1, 1, 0, 1, 1, 10'h3FF, 8'hFF);
    cyc("R9");
    cyc("R9");
    rst = 0;
    set(1, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) cyc("R2");
    set(0, 1, 1, 1, 1, 1, 10'h2AA, 8'h77);   // no step: nothing moves (R1)
    cyc("R1");
    set(1, 0, 0, 0, 0, 1, 0, 8'hFD);         // buffer <= 5 (R7)
    cyc("R7");
    set(1, 1, 0, 0, 0, 0, 10'h155, 0);       // jump -> 0x555 (R3)
    cyc("R3");
    set(1, 0, 0, 0, 1, 0, 0, 8'h3C);         // low write -> 0x53C (R6)
    cyc("R6");
    set(1, 0, 0, 0, 1, 0, 0, 8'hFF);         // -> 0x5FF
    cyc("R6");
    set(1, 0, 0, 0, 0, 1, 0, 8'h07);         // buffer 7
    cyc("R7");
    set(1, 0, 0, 0, 1, 0, 0, 8'hFF);         // -> 0x7FF
    cyc("R6");
    set(1, 0, 0, 0, 0, 0, 0, 0);             // wraps to 0 (R2)
    cyc("R2");
    // jump together with buffer write uses old buffer (R7)
    set(1, 1, 0, 0, 0, 1, 10'h001, 8'h00);
    cyc("R7");
    // six calls then six returns: ring wrap (R8)
    for (int i = 0; i < 6; i++) begin
      set(1, 0, 1, 0, 0, 0, 10'h040 * (i + 1) + i, 0);
      cyc("R8");
    end
    for (int i = 0; i < 6; i++) begin
      set(1, 0, 0, 1, 0, 0, 0, 0);
      cyc("R8");
    end
    // precedence combinations (R10)
    set(1, 1, 1, 1, 1, 0, 10'h100, 8'h11); cyc("R10");
    set(1, 1, 1, 0, 1, 0, 10'h0F0, 8'h22); cyc("R10");
    set(1, 1, 0, 0, 1, 0, 10'h0A5, 8'h33); cyc("R10");
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      set(r < 90, $urandom_range(0, 6) == 0, $urandom_range(0, 6) == 0,
          $urandom_range(0, 6) == 0, $urandom_range(0, 6) == 0,
          $urandom_range(0, 5) == 0, $urandom_range(0, 1023), $urandom_range(0, 255));
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule